// File: doc/BRIEF.md
# Strided Block Access Scheduler

This block schedules one vector repeat of eight 32-byte blocks against a banked scratch memory. A requester supplies a base byte address and a block stride counted in 32-byte rows. From these the scheduler forms the eight block addresses. On every cycle it then issues the largest group of still-pending blocks that can be served together. The memory serves one row per bank group per cycle, so two blocks may share a cycle only when they map to different bank groups.

The same rule covers both source reads and destination writes, so one scheduler can be placed in front of either path. The number of cycles a repeat takes depends on how the stride aliases onto the sixteen bank groups. A unit stride completes in one cycle. A stride that folds every block onto one group takes eight. When the last block has been issued, a one-cycle done pulse reports how many issue cycles the repeat used.

Top module: `sbas_sched`

## Requirements
- R1: After reset, `busy_o`, `done_o` and every bit of `issue_o` are low.
- R2: `start_i` is accepted only in a cycle where `busy_o` is low. A start raised while busy is ignored: the block addresses and the cycle count of the repeat in flight are unchanged.
- R3: While busy, lane i of `blk_addr_o` (bits [i*ADDR_W +: ADDR_W]) equals (base + i × stride × 32) modulo 2^ADDR_W.
- R4: The bank group of a block is bits [8:5] of its address. In any cycle, no two blocks issued together share a bank group.
- R5: Bit i of `issue_o` marks block i. Each of the eight blocks is issued exactly once per repeat.
- R6: Pending blocks are granted in ascending index. Block i is issued in issue cycle 1 + n, where n is the number of lower-index blocks in its bank group, so every cycle serves the largest conflict-free set.
- R7: `done_o` is high for exactly one cycle, the cycle after the last issue cycle. In that cycle `busy_o` is already low and `cycles_o` equals the number of issue cycles: the largest number of blocks sharing one bank group, from 1 to 8.
- R8: From base 0x1FE00, a stride of 16 takes 8 cycles and a stride of 8 takes 4. A stride of 1 takes 1 cycle. A stride of 0 makes all eight blocks identical and takes 8 cycles.
- R9: `issue_o` is nonzero in every busy cycle and zero whenever `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin a repeat |
| base_i | input | ADDR_W (18) | Byte address of block 0 |
| stride_i | input | STRIDE_W (8) | Block stride in 32-byte rows |
| busy_o | output | 1 | A repeat is in progress |
| issue_o | output | NBLK (8) | Blocks issued this cycle, one bit per block |
| blk_addr_o | output | NBLK*ADDR_W (144) | Addresses of the eight blocks, lane i for block i |
| done_o | output | 1 | One-cycle pulse after the final issue cycle |
| cycles_o | output | CNT_W (4) | Issue cycles used by the finished repeat |

## Verification
The bench sweeps all 256 stride values from four base addresses: zero, 0x1FE00, a base just below the top of the address space so that block addresses wrap, and an unaligned middle address. Because the bases differ, the same stride starts from a different bank-group phase, which exposes mistakes in address arithmetic and in group extraction. The per-block issue cycle is predicted from a rank count inside each group. This rank check separates a correct in-order maximal grant from schedules that are merely conflict-free or that give priority in the wrong order. On alternating repeats, starts carrying different operands are raised throughout the busy window to show that the repeat in flight is left undisturbed.

// File: rtl/sbas_pkg.sv
package sbas_pkg;

  localparam int unsigned SBAS_NBLK     = 8;
  localparam int unsigned SBAS_ROW_LG   = 5;
  localparam int unsigned SBAS_GRP_W    = 4;

  // Byte offset of block idx for a stride counted in rows of 2**row_lg bytes.
  function automatic logic [31:0] blk_offset(input int unsigned idx,
                                             input logic [31:0] stride,
                                             input int unsigned row_lg);
    logic [31:0] rows;
    rows = 32'(idx) * stride;
    return rows << row_lg;
  endfunction

  // Bank-group index: the field just above the row offset.
  function automatic logic [31:0] grp_of(input logic [31:0] addr,
                                         input int unsigned lo,
                                         input int unsigned w);
    logic [31:0] mask;
    mask = (32'd1 << w) - 32'd1;
    return (addr >> lo) & mask;
  endfunction

endpackage

// File: rtl/sbas_addr_gen.sv
module sbas_addr_gen #(
  parameter int unsigned NBLK     = 8,
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned STRIDE_W = 8,
  parameter int unsigned ROW_LG   = 5
) (
  input  logic [ADDR_W-1:0]      base_i,
  input  logic [STRIDE_W-1:0]    stride_i,
  output logic [NBLK*ADDR_W-1:0] addr_o
);
  import sbas_pkg::*;

  localparam int unsigned PAD_W = 32 - STRIDE_W;

  logic [31:0] stride_ext;
  assign stride_ext = {{PAD_W{1'b0}}, stride_i};

  for (genvar i = 0; i < NBLK; i++) begin : g_lane
    logic [ADDR_W-1:0] off_w;
    assign off_w = ADDR_W'(blk_offset(i, stride_ext, ROW_LG));
    assign addr_o[i*ADDR_W +: ADDR_W] = base_i + off_w;
  end

endmodule

// File: rtl/sbas_grp_arb.sv
module sbas_grp_arb #(
  parameter int unsigned NBLK   = 8,
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned ROW_LG = 5,
  parameter int unsigned GRP_W  = 4
) (
  input  logic [NBLK-1:0]        pending_i,
  input  logic [NBLK*ADDR_W-1:0] addr_i,
  output logic [NBLK-1:0]        grant_o
);
  import sbas_pkg::*;

  logic [GRP_W-1:0] grp_w [NBLK];

  for (genvar i = 0; i < NBLK; i++) begin : g_grp
    assign grp_w[i] = GRP_W'(grp_of(32'(addr_i[i*ADDR_W +: ADDR_W]), ROW_LG, GRP_W));
  end

  // A pending block loses only to a lower-index pending block of its group.
  logic [NBLK-1:0] blocked_w;
  always_comb begin
    blocked_w = '0;
    for (int i = 0; i < NBLK; i++) begin
      for (int j = 0; j < NBLK; j++) begin
        if (j < i && pending_i[j] && grp_w[j] == grp_w[i]) begin
          blocked_w[i] = 1'b1;
        end
      end
    end
  end

  assign grant_o = pending_i & ~blocked_w;

endmodule

// File: rtl/sbas_sched.sv
module sbas_sched #(
  parameter int unsigned NBLK     = sbas_pkg::SBAS_NBLK,
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned STRIDE_W = 8,
  parameter int unsigned ROW_LG   = sbas_pkg::SBAS_ROW_LG,
  parameter int unsigned GRP_W    = sbas_pkg::SBAS_GRP_W,
  parameter int unsigned CNT_W    = $clog2(NBLK + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [ADDR_W-1:0]      base_i,
  input  logic [STRIDE_W-1:0]    stride_i,
  output logic                   busy_o,
  output logic [NBLK-1:0]        issue_o,
  output logic [NBLK*ADDR_W-1:0] blk_addr_o,
  output logic                   done_o,
  output logic [CNT_W-1:0]       cycles_o
);

  logic [ADDR_W-1:0]   base_q;
  logic [STRIDE_W-1:0] stride_q;
  logic [NBLK-1:0]     pending_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                busy_q;
  logic                done_q;
  logic [CNT_W-1:0]    cycles_q;

  // Named internal events.
  logic                accept_w;
  logic [NBLK-1:0]     grant_w;
  logic [NBLK-1:0]     remain_w;
  logic                last_w;
  logic [NBLK*ADDR_W-1:0] addr_w;

  sbas_addr_gen #(
    .NBLK(NBLK), .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .ROW_LG(ROW_LG)
  ) u_addr (
    .base_i  (base_q),
    .stride_i(stride_q),
    .addr_o  (addr_w)
  );

  sbas_grp_arb #(
    .NBLK(NBLK), .ADDR_W(ADDR_W), .ROW_LG(ROW_LG), .GRP_W(GRP_W)
  ) u_arb (
    .pending_i(pending_q),
    .addr_i   (addr_w),
    .grant_o  (grant_w)
  );

  assign accept_w = start_i & ~busy_q;
  assign remain_w = pending_q & ~grant_w;
  assign last_w   = busy_q & (remain_w == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      stride_q  <= '0;
      pending_q <= '0;
      cnt_q     <= '0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      cycles_q  <= '0;
    end else begin
      done_q <= last_w;
      if (accept_w) begin
        base_q    <= base_i;
        stride_q  <= stride_i;
        pending_q <= '1;
        cnt_q     <= '0;
        busy_q    <= 1'b1;
      end else if (busy_q) begin
        pending_q <= remain_w;
        cnt_q     <= cnt_q + 1'b1;
        if (last_w) begin
          busy_q   <= 1'b0;
          cycles_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign busy_o     = busy_q;
  assign issue_o    = grant_w;
  assign blk_addr_o = addr_w;
  assign done_o     = done_q;
  assign cycles_o   = cycles_q;

endmodule

// File: rtl/sbas_sched_chk.sv
module sbas_sched_chk #(
  parameter int unsigned NBLK   = 8,
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned ROW_LG = 5,
  parameter int unsigned GRP_W  = 4,
  parameter int unsigned CNT_W  = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   busy_o,
  input logic [NBLK-1:0]        issue_o,
  input logic [NBLK*ADDR_W-1:0] blk_addr_o,
  input logic                   done_o,
  input logic [CNT_W-1:0]       cycles_o
);

  // Two issued blocks landing in one bank group.
  logic clash_w;
  always_comb begin
    clash_w = 1'b0;
    for (int i = 0; i < NBLK; i++) begin
      for (int j = 0; j < NBLK; j++) begin
        if (j < i && issue_o[i] && issue_o[j] &&
            blk_addr_o[i*ADDR_W+ROW_LG +: GRP_W] == blk_addr_o[j*ADDR_W+ROW_LG +: GRP_W]) begin
          clash_w = 1'b1;
        end
      end
    end
  end

  // Blocks already issued in the current repeat.
  logic [NBLK-1:0] seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seen_q <= '0;
    else if (done_o) seen_q <= '0;
    else             seen_q <= seen_q | issue_o;
  end

  a_r4_group_unique: assert property (@(posedge clk) disable iff (!rst_n) !clash_w);
  a_r5_no_reissue:   assert property (@(posedge clk) disable iff (!rst_n) (seen_q & issue_o) == '0);
  a_r5_all_served:   assert property (@(posedge clk) disable iff (!rst_n) done_o |-> seen_q == '1);
  a_r7_done_pulse:   assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o);
  a_r7_done_idle:    assert property (@(posedge clk) disable iff (!rst_n) $fell(busy_o) |-> done_o);
  a_r7_count_range:  assert property (@(posedge clk) disable iff (!rst_n)
                                      done_o |-> (cycles_o >= 1 && cycles_o <= CNT_W'(NBLK)));
  a_r9_idle_quiet:   assert property (@(posedge clk) disable iff (!rst_n) !busy_o |-> issue_o == '0);
  a_r9_busy_issues:  assert property (@(posedge clk) disable iff (!rst_n) busy_o |-> issue_o != '0);
  a_r2_addr_hold:    assert property (@(posedge clk) disable iff (!rst_n)
                                      (busy_o && $past(busy_o)) |-> $stable(blk_addr_o));

endmodule

bind sbas_sched sbas_sched_chk #(
  .NBLK(NBLK), .ADDR_W(ADDR_W), .ROW_LG(ROW_LG), .GRP_W(GRP_W), .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy_o    (busy_o),
  .issue_o   (issue_o),
  .blk_addr_o(blk_addr_o),
  .done_o    (done_o),
  .cycles_o  (cycles_o)
);

// File: tb/sbas_sched_test.sv
module sbas_sched_test;

  localparam int NB = 8;
  localparam int AW = 18;
  localparam int SW = 8;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [AW-1:0] base_i = '0;
  logic [SW-1:0] stride_i = '0;
  logic busy_o;
  logic [NB-1:0] issue_o;
  logic [NB*AW-1:0] blk_addr_o;
  logic done_o;
  logic [CW-1:0] cycles_o;

  int n_run = 0;
  int n_fail = 0;
  int ticks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sbas_sched uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
    .stride_i(stride_i), .busy_o(busy_o), .issue_o(issue_o),
    .blk_addr_o(blk_addr_o), .done_o(done_o), .cycles_o(cycles_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Runs one repeat and returns the reported cycle count.
  task automatic run_repeat(input int b, input int s, input bit garble, output int got);
    int addr_e [NB];
    int rank_e [NB];
    int exp_cyc;
    int c;
    logic [NB-1:0] exp_iss;
    bit addr_ok;
    exp_cyc = 0;
    for (int i = 0; i < NB; i++) begin
      addr_e[i] = (b + i * s * 32) % (1 << AW);
      rank_e[i] = 0;
      for (int j = 0; j < i; j++)
        if (((addr_e[j] >> 5) & 15) == ((addr_e[i] >> 5) & 15)) rank_e[i]++;
      if (rank_e[i] + 1 > exp_cyc) exp_cyc = rank_e[i] + 1;
    end
    @(negedge clk);
    start_i = 1'b1; base_i = AW'(b); stride_i = SW'(s);
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o === 1'b1, "R2", "busy after idle start", longint'(busy_o), 1);
    c = 1;
    while (busy_o === 1'b1 && c <= NB + 2) begin
      exp_iss = '0;
      for (int i = 0; i < NB; i++) if (rank_e[i] + 1 == c) exp_iss[i] = 1'b1;
      // R6 issue order; R9 nonzero while busy follows from exp_iss
      chk(issue_o === exp_iss, "R6", "issue vector", longint'(issue_o), longint'(exp_iss));
      addr_ok = 1'b1;
      for (int i = 0; i < NB; i++)
        if (blk_addr_o[i*AW +: AW] !== AW'(addr_e[i])) addr_ok = 1'b0;
      chk(addr_ok, garble ? "R2" : "R3", "block addresses", longint'(blk_addr_o[AW-1:0]),
          longint'(addr_e[0]));
      if (garble) begin
        start_i = 1'b1; base_i = AW'(b ^ 'h155); stride_i = SW'(s + 3);
      end
      @(negedge clk);
      start_i = 1'b0;
      c++;
    end
    chk(c <= NB + 1, "R7", "repeat bounded", c - 1, exp_cyc);
    chk(done_o === 1'b1, "R7", "done after last issue", longint'(done_o), 1);
    chk(int'(cycles_o) == exp_cyc && c - 1 == exp_cyc, "R7", "cycle count",
        longint'(cycles_o), exp_cyc);
    chk(issue_o === '0, "R9", "no issue when idle", longint'(issue_o), 0);
    got = int'(cycles_o);
    @(negedge clk);
    chk(done_o === 1'b0, "R7", "done one cycle", longint'(done_o), 0);
  endtask

  always @(posedge clk) begin
    ticks++;
    if (ticks > 150000 && !finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000", ticks);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int got;
    int bases [4];
    bases[0] = 0; bases[1] = 'h1FE00; bases[2] = 'h3FFE0; bases[3] = 'h12344;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy_o === 1'b0 && done_o === 1'b0 && issue_o === '0, "R1", "reset outputs",
        longint'({busy_o, done_o, issue_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o === 1'b0 && issue_o === '0, "R1", "idle after reset",
        longint'({busy_o, issue_o}), 0);

    // R8: named cases
    run_repeat('h1FE00, 16, 0, got);
    chk(got == 8, "R8", "stride 16 from 0x1FE00", got, 8);
    run_repeat('h1FE00, 8, 0, got);
    chk(got == 4, "R8", "stride 8 from 0x1FE00", got, 4);
    run_repeat('h1FE00, 1, 0, got);
    chk(got == 1, "R8", "stride 1", got, 1);
    run_repeat('h00400, 0, 1, got);
    chk(got == 8, "R8", "stride 0", got, 8);

    // R3 R4 R5 R6 R7: sweep every stride from four bases
    for (int bi = 0; bi < 4; bi++)
      for (int s = 0; s < 256; s++)
        run_repeat(bases[bi], s, s[0], got);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule